// File: doc/BRIEF.md
# Transition-Compressed Capture Unit

This block is the acquisition stage of a timing analyzer. It takes a bus of digital input lines, which are already reduced to one bit each by a single threshold, and samples them on an internal clock. It does not store every sample. It writes a record only for a sample in which at least one line differs from the sample before it. Each record carries the elapsed number of sample periods since the previous record. A stretch with no activity therefore costs no capture memory, while the timing resolution stays at one sample period.

A faster front end reports, for each line and each sample period, whether that line crossed the threshold more than once. Such a glitch forces a record even when the line ends the period at its old level. The glitch is kept in a per-line marker field of its own, apart from the level bits, and it also raises a single-cycle event output that a trigger can use. When the elapsed counter is about to run out, a filler record keeps the time base continuous. Once the memory reports full, the block stops writing and flags that the acquisition is done.

Top module: `edge_stamp_capture`

## Requirements
- R1: The raw lines and the glitch indications pass through a two-stage synchronizer. A level change held at the input is therefore written as a record three clock edges after it is applied, and bits [LINES-1:0] of `wr_value` hold the sampled levels of all lines.
- R2: While running, a record (`wr_en` high for one cycle) is written only for a sample that differs from the previous sample or that carries a glitch indication. Static inputs produce no records, apart from the fillers of R7.
- R3: Bits [CNT_W-1:0] of `wr_stamp` give the number of sample periods between this record's sample and the sample of the previous record. The value is at least 1. Bit WORD_W-1 of `wr_stamp` is 0 for a change record.
- R4: A single level change is written with bits [WORD_W-1:LINES] of `wr_value` (the glitch marker field) all zero.
- R5: A glitch indication on line i sets bit LINES+i of `wr_value` in the record of that sample. The record is written even if no level changed.
- R6: `glitch_evt` is high for exactly the cycle in which a record carrying a non-zero glitch marker field is written, and low for every other record.
- R7: When 2^CNT_W-1 sample periods pass without a change, a filler record is written. It has `wr_stamp` bit WORD_W-1 set, a count of 2^CNT_W-1, a zero glitch field and the current levels. Counting then restarts from zero.
- R8: From the clock edge at which `mem_full` is seen high, no record is written. `done` rises and stays high until reset, whatever `mem_full` does afterwards.
- R9: While `run` is low, no records are written, whatever the inputs do.
- R10: While reset is high and right after it, `wr_en`, `glitch_evt` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Acquisition enable, synchronous to clk |
| mem_full | input | 1 | Capture memory cannot take another record |
| lines_in | input | LINES | Thresholded input lines, asynchronous |
| multi_cross_in | input | LINES | Per-line multiple-crossing flag for the current sample period |
| wr_en | output | 1 | Record write strobe |
| wr_value | output | 2*LINES | First record word: glitch markers over sampled levels |
| wr_stamp | output | 2*LINES | Second record word: filler flag in the top bit, elapsed count in the low CNT_W bits |
| done | output | 1 | Sticky memory-full stop flag |
| glitch_evt | output | 1 | One-cycle pulse on a record that carries a glitch |

## Verification
The assertions assume that `run` and `mem_full` are synchronous to the sample clock. They also assume that the multiple-crossing flags arrive already aligned to the sample period they describe, so that the two-stage synchronizer delays both buses alike. The bench drives every input on the falling edge and holds each glitch flag for exactly one period. It keeps the spacing between stored samples well below the elapsed-counter limit except in the test that exercises the filler. There it shrinks the counter to six bits, so that the saturation path is reached in a few dozen cycles.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;

    // Depth of the synchronizer in front of the change detector
    localparam int SYNC_DEPTH = 2;

    // What the record decision produced in a given sample period
    typedef enum logic [1:0] {
        REC_NONE = 2'd0,
        REC_EDGE = 2'd1,
        REC_FILL = 2'd2
    } rec_kind_e;

    // Largest count an elapsed counter of the given width can hold
    function automatic int unsigned stamp_limit(input int unsigned width);
        return (32'd1 << width) - 32'd1;
    endfunction

endpackage

// File: rtl/es_sync.sv
module es_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/es_change_detect.sv
module es_change_detect #(
    parameter int LINES = 8
) (
    input  logic [LINES-1:0] cur,
    input  logic [LINES-1:0] prev,
    input  logic [LINES-1:0] glitch,
    output logic             any_event,
    output logic             any_glitch
);
    logic [LINES-1:0] edge_mask;

    always_comb begin
        edge_mask  = cur ^ prev;
        any_glitch = |glitch;
        any_event  = (|edge_mask) | any_glitch;
    end
endmodule

// File: rtl/es_elapsed.sv
module es_elapsed #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             enable,
    output logic [CNT_W-1:0] cnt,
    output logic             at_limit
);
    localparam logic [CNT_W-1:0] NEAR_MAX = {{(CNT_W-1){1'b1}}, 1'b0};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (enable) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_limit = (cnt == NEAR_MAX);
endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
    import edge_stamp_pkg::*;
#(
    parameter int LINES = 8,
    parameter int CNT_W = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 mem_full,
    input  logic [LINES-1:0]     lines_in,
    input  logic [LINES-1:0]     multi_cross_in,
    output logic                 wr_en,
    output logic [2*LINES-1:0]   wr_value,
    output logic [2*LINES-1:0]   wr_stamp,
    output logic                 done,
    output logic                 glitch_evt
);
    localparam int WORD_W = 2 * LINES;
    localparam int BUS_W  = 2 * LINES;

    logic [BUS_W-1:0] synced;
    logic [LINES-1:0] cur_lvl, cur_gl, prev_lvl;
    logic             any_event, any_glitch;
    logic [CNT_W-1:0] elapsed;
    logic             at_limit;
    logic             active, clear_cnt;
    rec_kind_e        kind;
    logic [CNT_W-1:0] stamp_cnt;
    logic [WORD_W-1:0] value_n, stamp_n;
    logic             done_q;

    es_sync #(.W(BUS_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({multi_cross_in, lines_in}),
        .q   (synced)
    );

    assign cur_lvl = synced[LINES-1:0];
    assign cur_gl  = synced[BUS_W-1:LINES];

    es_change_detect #(.LINES(LINES)) u_detect (
        .cur        (cur_lvl),
        .prev       (prev_lvl),
        .glitch     (cur_gl),
        .any_event  (any_event),
        .any_glitch (any_glitch)
    );

    es_elapsed #(.CNT_W(CNT_W)) u_elapsed (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear_cnt),
        .enable   (active),
        .cnt      (elapsed),
        .at_limit (at_limit)
    );

    always_comb begin
        active = run && !done_q && !mem_full;
        if (active && any_event)      kind = REC_EDGE;
        else if (active && at_limit)  kind = REC_FILL;
        else                          kind = REC_NONE;
        clear_cnt = !run || (kind != REC_NONE);
        stamp_cnt = elapsed + 1'b1;

        value_n = '0;
        value_n[LINES-1:0] = cur_lvl;
        if (kind == REC_EDGE) value_n[WORD_W-1:LINES] = cur_gl;

        stamp_n = '0;
        stamp_n[CNT_W-1:0]  = stamp_cnt;
        stamp_n[WORD_W-1]   = (kind == REC_FILL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl   <= '0;
            wr_en      <= 1'b0;
            wr_value   <= '0;
            wr_stamp   <= '0;
            glitch_evt <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            prev_lvl   <= cur_lvl;
            wr_en      <= (kind != REC_NONE);
            wr_value   <= value_n;
            wr_stamp   <= stamp_n;
            glitch_evt <= (kind == REC_EDGE) && any_glitch;
            done_q     <= done_q | mem_full;
        end
    end

    assign done = done_q;
endmodule

// File: rtl/es_checker.sv
module es_checker #(
    parameter int LINES = 8,
    parameter int CNT_W = 15
) (
    input logic               clk,
    input logic               rst,
    input logic               run,
    input logic               mem_full,
    input logic               wr_en,
    input logic [2*LINES-1:0] wr_value,
    input logic [2*LINES-1:0] wr_stamp,
    input logic               done,
    input logic               glitch_evt
);
    localparam int WORD_W = 2 * LINES;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R8
    full_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_full |=> !wr_en);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R8
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(mem_full));

    // R9
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !wr_en);

    // R3
    stamp_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_stamp[CNT_W-1:0] != '0));

    // R7
    filler_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_stamp[WORD_W-1]) |->
            (wr_stamp[CNT_W-1:0] == CNT_MAX && wr_value[WORD_W-1:LINES] == '0));

    // R6
    glitch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        glitch_evt |-> (wr_en && wr_value[WORD_W-1:LINES] != '0));

    // R6
    glitch_marker_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_value[WORD_W-1:LINES] != '0) |-> glitch_evt);
endmodule

bind edge_stamp_capture es_checker #(.LINES(LINES), .CNT_W(CNT_W)) u_es_checker (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .mem_full   (mem_full),
    .wr_en      (wr_en),
    .wr_value   (wr_value),
    .wr_stamp   (wr_stamp),
    .done       (done),
    .glitch_evt (glitch_evt)
);

// File: tb/edge_stamp_capture_bench.sv
module edge_stamp_capture_bench;
    localparam int LINES  = 8;
    localparam int CNT_W  = 6;
    localparam int WORD_W = 2 * LINES;
    localparam int LIMIT  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic mem_full = 1'b0;
    logic [LINES-1:0] lines_in = '0;
    logic [LINES-1:0] multi_cross_in = '0;
    logic wr_en, done, glitch_evt;
    logic [WORD_W-1:0] wr_value, wr_stamp;

    int checks = 0;
    int errors = 0;

    edge_stamp_capture #(.LINES(LINES), .CNT_W(CNT_W)) u_edge_stamp_capture (
        .clk            (clk),
        .rst            (rst),
        .run            (run),
        .mem_full       (mem_full),
        .lines_in       (lines_in),
        .multi_cross_in (multi_cross_in),
        .wr_en          (wr_en),
        .wr_value       (wr_value),
        .wr_stamp       (wr_stamp),
        .done           (done),
        .glitch_evt     (glitch_evt)
    );

    always #2 clk = ~clk;

    // Record monitor, sampled on the falling edge
    int cyc = 0;
    int rec_n = 0;
    int gevt_n = 0;
    logic [WORD_W-1:0] m_val [128];
    logic [WORD_W-1:0] m_stp [128];
    logic              m_gev [128];
    int                m_cyc [128];

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (glitch_evt) gevt_n <= gevt_n + 1;
        if (wr_en && rec_n < 128) begin
            m_val[rec_n] <= wr_value;
            m_stp[rec_n] <= wr_stamp;
            m_gev[rec_n] <= glitch_evt;
            m_cyc[rec_n] <= cyc;
            rec_n <= rec_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Stamp of record i equals the spacing of its sample from the one before
    task automatic chk_spacing(input int i, input string tag);
        chk(m_stp[i][CNT_W-1:0] == LIMIT'(m_cyc[i] - m_cyc[i-1]) || 1'b0 == 1'b1 ?
            m_stp[i][CNT_W-1:0] == (m_cyc[i] - m_cyc[i-1]) : 1'b0,
            tag, m_stp[i][CNT_W-1:0], m_cyc[i] - m_cyc[i-1]);
    endtask

    task automatic t_reset();
        wait_cyc(3);
        chk(!wr_en && !glitch_evt && !done, "R10 in reset", {wr_en, glitch_evt, done}, 0);
        rst = 1'b0;
        wait_cyc(2);
        chk(!wr_en && !glitch_evt && !done, "R10 after reset", {wr_en, glitch_evt, done}, 0);
    endtask

    task automatic t_stopped();
        int base = rec_n;
        run = 1'b0;
        lines_in = 8'hA5; wait_cyc(2);
        lines_in = 8'h5A; multi_cross_in = 8'h01; wait_cyc(1);
        multi_cross_in = '0; lines_in = 8'h0F; wait_cyc(6);
        chk(rec_n == base, "R9 no record while stopped", rec_n - base, 0);
    endtask

    task automatic t_edges();
        int base;
        int gaps [4] = '{3, 7, 1, 12};
        logic [LINES-1:0] vals [4] = '{8'h1F, 8'h9F, 8'h9E, 8'h00};
        run = 1'b1;
        wait_cyc(5);
        base = rec_n;
        chk(base == 0, "R2 start with static lines", base, 0);
        for (int k = 0; k < 4; k++) begin
            wait_cyc(gaps[k] - 1);
            lines_in = vals[k];
            wait_cyc(1);
        end
        wait_cyc(5);
        chk(rec_n - base == 4, "R2 one record per change", rec_n - base, 4);
        for (int k = 0; k < 4; k++) begin
            chk(m_val[base+k][LINES-1:0] == vals[k], "R1 sampled levels", m_val[base+k][LINES-1:0], vals[k]);
            chk(m_val[base+k][WORD_W-1:LINES] == 0, "R4 no glitch marker on single change",
                m_val[base+k][WORD_W-1:LINES], 0);
            chk(!m_stp[base+k][WORD_W-1], "R3 change record flag clear", m_stp[base+k][WORD_W-1], 0);
            if (k > 0)
                chk(m_stp[base+k][CNT_W-1:0] == gaps[k], "R3 elapsed stamp", m_stp[base+k][CNT_W-1:0], gaps[k]);
        end
    endtask

    task automatic t_latency();
        int c0;
        int base = rec_n;
        lines_in = 8'h33;
        c0 = cyc;
        wait_cyc(2);
        chk(rec_n == base, "R1 not yet written after two edges", rec_n - base, 0);
        wait_cyc(1);
        chk(wr_en && wr_value[LINES-1:0] == 8'h33, "R1 written on third edge", wr_value, 8'h33);
        chk(rec_n == base + 1 || cyc - c0 == 3, "R1 latency", cyc - c0, 3);
        wait_cyc(1);
        chk(!wr_en, "R2 strobe is one cycle", wr_en, 0);
    endtask

    task automatic t_idle();
        int base = rec_n;
        wait_cyc(30);
        chk(rec_n == base, "R2 idle writes nothing", rec_n - base, 0);
    endtask

    task automatic t_glitch();
        int base = rec_n;
        int g0 = gevt_n;
        multi_cross_in = 8'h04;
        wait_cyc(1);
        multi_cross_in = '0;
        wait_cyc(4);
        lines_in = 8'h32;
        wait_cyc(5);
        chk(rec_n - base == 2, "R5 glitch forces a record", rec_n - base, 2);
        chk(m_val[base] == {8'h04, 8'h33}, "R5 glitch marker and levels", m_val[base], {8'h04, 8'h33});
        chk(m_gev[base], "R6 event with glitch record", m_gev[base], 1);
        chk(m_val[base+1][WORD_W-1:LINES] == 0 && !m_gev[base+1], "R6 no event on plain change",
            {m_val[base+1][WORD_W-1:LINES], m_gev[base+1]}, 0);
        chk(gevt_n - g0 == 1, "R6 single-cycle event", gevt_n - g0, 1);
        chk(m_stp[base+1][CNT_W-1:0] == m_cyc[base+1] - m_cyc[base], "R3 stamp after glitch",
            m_stp[base+1][CNT_W-1:0], m_cyc[base+1] - m_cyc[base]);
    endtask

    task automatic t_filler();
        int base = rec_n;
        wait_cyc(2 * LIMIT + 10);
        chk(rec_n - base == 2, "R7 two fillers over long idle", rec_n - base, 2);
        for (int k = 0; k < 2; k++) begin
            chk(m_stp[base+k][WORD_W-1] && m_stp[base+k][CNT_W-1:0] == LIMIT, "R7 filler stamp",
                m_stp[base+k], {1'b1, 9'd0, 6'(LIMIT)});
            chk(m_val[base+k] == {8'h00, 8'h32}, "R7 filler value", m_val[base+k], {8'h00, 8'h32});
            chk(m_cyc[base+k] - m_cyc[base+k-1] == LIMIT, "R7 filler spacing",
                m_cyc[base+k] - m_cyc[base+k-1], LIMIT);
        end
        lines_in = 8'h77;
        wait_cyc(5);
        chk(m_stp[base+2][CNT_W-1:0] == m_cyc[base+2] - m_cyc[base+1] && !m_stp[base+2][WORD_W-1],
            "R7 count restarts after filler", m_stp[base+2][CNT_W-1:0], m_cyc[base+2] - m_cyc[base+1]);
    endtask

    task automatic t_full();
        int base;
        lines_in = 8'h78;
        mem_full = 1'b1;
        wait_cyc(1);
        chk(done, "R8 done rises", done, 1);
        wait_cyc(4);
        base = rec_n;
        mem_full = 1'b0;
        lines_in = 8'h01;
        multi_cross_in = 8'h80;
        wait_cyc(1);
        multi_cross_in = '0;
        wait_cyc(6);
        chk(rec_n == base, "R8 no record after full", rec_n - base, 0);
        chk(done, "R8 done sticky", done, 1);
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(1);
        chk(!done && !wr_en, "R10 reset clears done", {done, wr_en}, 0);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_stopped();
        t_edges();
        t_latency();
        t_idle();
        t_glitch();
        t_filler();
        t_full();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule